// File: doc/BRIEF.md
# External memory bus sequencer

This block generates the strobe and address/data timing that an 8-bit controller core uses to reach memory outside the chip. Time is divided into machine cycles of twelve clock periods, counted 0 to 11 here. Each cycle splits into six states of two clocks, and its halves begin at clocks 0 and 6. In every cycle the sequencer runs one of four kinds of work: an idle cycle, a code fetch of two consecutive bytes, a data read, or a data write. The cycle kind decides which strobes pulse and what the two external ports carry.

The core presents at most one request per machine cycle. The sequencer takes it at the last clock of the current cycle, which it marks with `slot`, and runs it in the next cycle. During a fetch the low byte of the address appears on the low port while the latch pulse is high, and the port then turns to input while the program strobe is active. A data cycle gives up the second latch pulse and both program strobes, and a read or write strobe spans the two halves in their place. The high port shows either the upper address byte or the core's own port register value, depending on the address width of the access. A reset filter ignores reset pulses shorter than two machine cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: Once `rst` has been sampled high on 24 consecutive rising edges, `ale` is 0, `psen`, `rd` and `wr` are 1, and `p0_oe`, `slot` and `rdata_valid` are 0 for as long as `rst` stays high. After `rst` falls, the first machine cycle is idle and begins at clock 0.
- R2: A `rst` pulse lasting fewer than 24 clocks has no effect. The strobes and `slot` keep their normal sequence.
- R3: Pin encoding with default parameters: `ale` is active high, and `psen`, `rd` and `wr` are active low. In an idle cycle with `ale_off` low, `ale` is active on clocks 0-1 and 6-7 only. `psen`, `rd` and `wr` stay inactive, and `slot` is high on clock 11 only.
- R4: In an idle cycle, `ale` stays inactive when `ale_off` is 1 and `ext_exec` is 0. `ale` pulses normally when `ext_exec` is 1.
- R5: In a fetch cycle, `ale` pulses on clocks 0-1 and 6-7 whatever the value of `ale_off`, and `psen` is active on clocks 2-5 and 8-11. `p0_oe` is high on clocks 0-1, carrying address bits 7:0, and on clocks 6-7, carrying bits 7:0 of address+1. `p2_out` shows the matching upper byte.
- R6: In a fetch cycle, `p0_in` is captured on the edges that end clocks 5 and 11. `rdata_valid` is high for one clock after each capture, with `rdata` holding the captured byte.
- R7: In a data read cycle, `ale` pulses on clocks 0-1 only and `psen` stays inactive. `rd` is active on clocks 2-11. `p0_in` is captured on the edge that ends clock 11 and is presented with `rdata_valid` on clock 0 of the next cycle.
- R8: In a data write cycle, `ale` pulses on clocks 0-1 only and `wr` is active on clocks 2-11. Throughout clocks 2-11, `p0_oe` is high and `p0_out` carries the write byte.
- R9: `p2_out` carries address bits 15:8 for fetches and for data accesses with `req_wide`=1. For data accesses with `req_wide`=0 and for idle cycles, it carries `p2_reg`.
- R10: The request inputs are sampled only on the edge that ends clock 11, where `slot` is high. The request runs in the machine cycle that follows. `req_data`=0 selects a fetch, and `req_data`=1 with `req_wr` selects a write (1) or a read (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Raw reset request, filtered over two machine cycles |
| req_valid | input | 1 | Access request for the next machine cycle |
| req_data | input | 1 | 1 = data access, 0 = code fetch |
| req_wr | input | 1 | Data access direction, 1 = write |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| ext_exec | input | 1 | Core executes from external code memory |
| ale_off | input | 1 | Control bit that limits the latch pulse to access cycles |
| p2_reg | input | 8 | High port register contents |
| p0_in | input | 8 | Low port input value |
| ale | output | 1 | Address latch pulse |
| psen | output | 1 | Program memory read strobe |
| rd | output | 1 | Data memory read strobe |
| wr | output | 1 | Data memory write strobe |
| p0_out | output | 8 | Low port drive value (zero when not driven) |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port drive value |
| rdata | output | 8 | Byte read back to the core |
| rdata_valid | output | 1 | `rdata` is new this clock |
| slot | output | 1 | Last clock of the machine cycle, where a request is taken |

## Verification
All strobes and port values decode directly from the registered cycle position. They therefore change one clock after a request is taken at clock 11, and the bench compares them at the falling edge of each of the twelve clocks that follow. A captured byte appears one clock after its capture edge: on clock 6 for the first fetch byte, and on clock 0 of the next cycle for the second fetch byte and for data reads. The bench checks the second case while it walks the next vector. The reset filter takes 24 edges, so idle levels are checked only after clock 25 of a held reset, and the restart is checked on the first clock after release.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int DW = 8,
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int RST_CYCLES = 2,
  parameter bit ALE_HI = 1'b1,
  parameter bit PSEN_HI = 1'b0,
  parameter bit RD_HI = 1'b0,
  parameter bit WR_HI = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_data,
  input  logic          req_wr,
  input  logic          req_wide,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ext_exec,
  input  logic          ale_off,
  input  logic [DW-1:0] p2_reg,
  input  logic [DW-1:0] p0_in,
  output logic          ale,
  output logic          psen,
  output logic          rd,
  output logic          wr,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [DW-1:0] p2_out,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid,
  output logic          slot
);
  localparam int AW = 2 * DW;
  localparam int CYC = STATES * PHASES;
  localparam int HALF = CYC / 2;
  localparam int PW = $clog2(CYC);
  localparam int RST_CLKS = RST_CYCLES * CYC;
  localparam int RW = $clog2(RST_CLKS + 1);
  localparam logic [PW-1:0] LAST = PW'(CYC - 1);
  localparam logic [PW-1:0] MIDCAP = PW'(HALF - 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] WIN = PW'(PHASES);
  localparam logic [1:0] K_IDLE = 2'd0, K_FETCH = 2'd1, K_RD = 2'd2, K_WR = 2'd3;

  logic [PW-1:0] ph;
  logic [1:0]    kind;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] wdat;
  logic          wide;
  logic          in_rst;
  logic [RW-1:0] hcnt;

  wire half = ph >= HALF_P;
  wire [PW-1:0] sub = half ? ph - HALF_P : ph;
  wire lead = sub < WIN;
  wire is_data = kind[1];
  wire [AW-1:0] naddr = cur_addr + AW'(1);
  wire [AW-1:0] baddr = (kind == K_FETCH && half) ? naddr : cur_addr;
  wire addr_phase = lead && (kind == K_FETCH || (is_data && !half));

  wire ale_a  = !in_rst && lead &&
                (kind == K_FETCH || (is_data && !half) ||
                 (kind == K_IDLE && (!ale_off || ext_exec)));
  wire psen_a = !in_rst && kind == K_FETCH && !lead;
  wire rd_a   = !in_rst && kind == K_RD && ph >= WIN;
  wire wr_a   = !in_rst && kind == K_WR && ph >= WIN;
  wire addr_a = !in_rst && addr_phase;
  wire cap    = !in_rst && ((kind == K_FETCH && (ph == MIDCAP || ph == LAST)) ||
                            (kind == K_RD && ph == LAST));

  assign ale    = ale_a  ? ALE_HI  : !ALE_HI;
  assign psen   = psen_a ? PSEN_HI : !PSEN_HI;
  assign rd     = rd_a   ? RD_HI   : !RD_HI;
  assign wr     = wr_a   ? WR_HI   : !WR_HI;
  assign p0_oe  = addr_a || wr_a;
  assign p0_out = addr_a ? baddr[DW-1:0] : (wr_a ? wdat : '0);
  assign p2_out = (!in_rst && (kind == K_FETCH || (is_data && wide))) ? baddr[AW-1:DW] : p2_reg;
  assign slot   = !in_rst && ph == LAST;

  always_ff @(posedge clk) begin
    if (!rst) begin
      hcnt   <= '0;
      in_rst <= 1'b0;
    end else begin
      if (hcnt != RW'(RST_CLKS - 1)) hcnt <= hcnt + RW'(1);
      else in_rst <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_rst) begin
      ph          <= '0;
      kind        <= K_IDLE;
      rdata_valid <= 1'b0;
      rdata       <= '0;
      cur_addr    <= '0;
      wdat        <= '0;
      wide        <= 1'b0;
    end else begin
      ph          <= (ph == LAST) ? '0 : ph + PW'(1);
      rdata_valid <= cap;
      if (cap) rdata <= p0_in;
      if (ph == LAST) begin
        kind     <= !req_valid ? K_IDLE : (!req_data ? K_FETCH : (req_wr ? K_WR : K_RD));
        cur_addr <= req_addr;
        wdat     <= req_wdata;
        wide     <= req_wide;
      end
    end
  end
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int PW = 4,
  parameter int HALF = 6,
  parameter int WIN = 2
) (
  input logic          clk,
  input logic          in_rst,
  input logic [PW-1:0] ph,
  input logic [1:0]    kind,
  input logic          ale_a,
  input logic          psen_a,
  input logic          rd_a,
  input logic          wr_a,
  input logic          p0_oe,
  input logic          rdata_valid
);
  logic live = 1'b0;
  always_ff @(posedge clk) if (in_rst === 1'b1) live <= 1'b1;

  // R10
  phase_step_chk: assert property (@(posedge clk) disable iff (!live)
    (!in_rst && !$past(in_rst)) |->
      ph == (($past(ph) == PW'(2*HALF-1)) ? PW'(0) : $past(ph) + PW'(1)));

  // R1
  restart_chk: assert property (@(posedge clk) disable iff (!live)
    $fell(in_rst) |-> (ph == '0 && kind == 2'd0));

  // R3
  ale_clear_chk: assert property (@(posedge clk) disable iff (!live)
    ale_a |-> !(psen_a || rd_a || wr_a));

  // R4
  ale_window_chk: assert property (@(posedge clk) disable iff (!live)
    ale_a |-> ((int'(ph) % HALF) < WIN));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!live)
    $onehot0({psen_a, rd_a, wr_a}));

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (!live)
    wr_a |-> p0_oe);

  // R6
  cap_chk: assert property (@(posedge clk) disable iff (!live)
    (rdata_valid && !in_rst) |-> $past(psen_a || rd_a));
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.PW(PW), .HALF(HALF), .WIN(PHASES)) chk_i (
  .clk(clk), .in_rst(in_rst), .ph(ph), .kind(kind), .ale_a(ale_a),
  .psen_a(psen_a), .rd_a(rd_a), .wr_a(wr_a), .p0_oe(p0_oe),
  .rdata_valid(rdata_valid)
);

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_data = 1'b0, req_wr = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, p2_reg = '0, p0_in = '0;
  logic ext_exec = 1'b0, ale_off = 1'b0;
  logic ale, psen, rd, wr, p0_oe, rdata_valid, slot;
  logic [7:0] p0_out, p2_out, rdata;

  always #2 clk = !clk;

  ext_bus_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data), .req_wr(req_wr),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata), .ext_exec(ext_exec),
    .ale_off(ale_off), .p2_reg(p2_reg), .p0_in(p0_in), .ale(ale), .psen(psen), .rd(rd),
    .wr(wr), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rdata(rdata),
    .rdata_valid(rdata_valid), .slot(slot)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind[47:46] wide[45] ale_off[44] ext[43] addr[39:24] wdata[23:16] base[15:8] p2reg[7:0]
  localparam int NV = 9;
  localparam logic [47:0] VECS [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h00, 8'h00, 8'h5A},
    {2'd1, 1'b0, 1'b1, 1'b0, 3'd0, 16'h12FF, 8'h00, 8'hA0, 8'h5A},
    {2'd2, 1'b1, 1'b0, 1'b0, 3'd0, 16'hBEEF, 8'h00, 8'h5C, 8'h5A},
    {2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 8'h00, 8'h00, 8'h5A},
    {2'd0, 1'b0, 1'b1, 1'b1, 3'd0, 16'h0000, 8'h00, 8'h00, 8'h5A},
    {2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 16'h3344, 8'h9D, 8'h00, 8'h71},
    {2'd2, 1'b0, 1'b1, 1'b0, 3'd0, 16'hFF10, 8'h00, 8'h3A, 8'hC3},
    {2'd1, 1'b0, 1'b0, 1'b1, 3'd0, 16'hFFFF, 8'h00, 8'h11, 8'hC3},
    {2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h00, 8'h00, 8'hC3}
  };

  function automatic logic [4:0] exp_strb(input logic [1:0] kd, input int k, input logic ao, input logic ex);
    logic lead, half, a, p, r, w;
    lead = (k % 6) < 2;
    half = k >= 6;
    a = lead && (kd == 2'd1 || (kd[1] && !half) || (kd == 2'd0 && (!ao || ex)));
    p = kd == 2'd1 && !lead;
    r = kd == 2'd2 && k >= 2;
    w = kd == 2'd3 && k >= 2;
    return {a, p, r, w, k == 11};
  endfunction

  function automatic logic [16:0] exp_bus(input logic [1:0] kd, input int k, input logic wd,
                                          input logic [15:0] ad, input logic [7:0] wdt, input logic [7:0] p2);
    logic lead, half, oe;
    logic [15:0] ba;
    logic [7:0] p0, hi;
    lead = (k % 6) < 2;
    half = k >= 6;
    ba = (kd == 2'd1 && half) ? ad + 16'd1 : ad;
    oe = 1'b0; p0 = 8'h00;
    if (lead && (kd == 2'd1 || (kd[1] && !half))) begin oe = 1'b1; p0 = ba[7:0]; end
    else if (kd == 2'd3 && k >= 2) begin oe = 1'b1; p0 = wdt; end
    hi = (kd == 2'd1 || (kd[1] && wd)) ? ba[15:8] : p2;
    return {oe, p0, hi};
  endfunction

  function automatic string strb_tag(input logic [1:0] kd);
    case (kd)
      2'd1: return "R5 R10 fetch strobes";
      2'd2: return "R7 R10 read strobes";
      2'd3: return "R8 R10 write strobes";
      default: return "R3 R4 R10 idle strobes";
    endcase
  endfunction

  task automatic strb_chk(input logic [1:0] kd, input int k, input logic ao, input logic ex, input string tag);
    logic [4:0] e, a;
    e = exp_strb(kd, k, ao, ex);
    a = {ale, !psen, !rd, !wr, slot};
    chk(a == e, tag, 32'(a), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] pk;
    logic [7:0] pb;
    // R1: held reset gives idle levels
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (n == 26)
        chk({ale, psen, rd, wr, p0_oe, slot, rdata_valid} == 7'b0111000, "R1 idle in reset",
            32'({ale, psen, rd, wr, p0_oe, slot, rdata_valid}), 32'h38);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(ale == 1'b1 && slot == 1'b0, "R1 restart at clock 0", 32'({ale, slot}), 32'h2);
    while (!slot) @(negedge clk);

    pk = 2'd0; pb = 8'h00;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kd;
      logic [7:0] base;
      kd = VECS[i][47:46];
      base = VECS[i][15:8];
      req_valid = kd != 2'd0;
      req_data = kd[1];
      req_wr = kd == 2'd3;
      req_wide = VECS[i][45];
      ale_off = VECS[i][44];
      ext_exec = VECS[i][43];
      req_addr = VECS[i][39:24];
      req_wdata = VECS[i][23:16];
      p2_reg = VECS[i][7:0];
      for (int k = 0; k < 12; k++) begin
        logic [16:0] eb, ab;
        logic ev;
        logic [7:0] ed;
        @(negedge clk);
        strb_chk(kd, k, ale_off, ext_exec, strb_tag(kd));
        eb = exp_bus(kd, k, req_wide, req_addr, req_wdata, p2_reg);
        ab = {p0_oe, p0_out, p2_out};
        chk(ab == eb, "R5 R8 R9 port values", 32'(ab), 32'(eb));
        ev = 1'b0; ed = 8'h00;
        if (k == 0 && (pk == 2'd1 || pk == 2'd2)) begin ev = 1'b1; ed = pb ^ 8'h0B; end
        if (k == 6 && kd == 2'd1) begin ev = 1'b1; ed = base ^ 8'h05; end
        chk({rdata_valid, rdata_valid ? rdata : 8'h00} == {ev, ed}, "R6 R7 read capture",
            32'({rdata_valid, rdata}), 32'({ev, ed}));
        p0_in = base ^ 8'(k);
        if (k == 0) req_valid = 1'b0;
      end
      pk = kd; pb = base;
    end

    // R2: short reset pulse is filtered out
    ale_off = 1'b0; ext_exec = 1'b0; rst = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      strb_chk(2'd0, k, 1'b0, 1'b0, "R2 short reset ignored");
      if (k == 8) rst = 1'b0;
    end

    // R1: long reset during a fetch
    req_valid = 1'b1; req_data = 1'b0; req_addr = 16'h2000; rst = 1'b1;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (n == 3) chk(psen == 1'b0, "R2 fetch runs before filter expires", 32'(psen), 32'h0);
      if (n == 26)
        chk({ale, psen, rd, wr, p0_oe, slot, rdata_valid} == 7'b0111000, "R1 idle after hold",
            32'({ale, psen, rd, wr, p0_oe, slot, rdata_valid}), 32'h38);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(ale == 1'b1 && psen == 1'b1 && slot == 1'b0, "R1 idle restart",
        32'({ale, psen, slot}), 32'h6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule